// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block owns the interrupt request of a single DMA channel in a bus bridge. The data engine reports the end of each descriptor's transfer. Alongside that report it gives three flags: whether the channel runs a chain of descriptors, whether the descriptor just finished carries its own interrupt request bit, and whether that descriptor was the last one in the chain. The descriptor's request bit comes from the pointer word fetched with the descriptor. The block turns these inputs into a level interrupt and a done status bit. Software reads the done status bit to tell two cases apart: an interrupt for a finished transfer, or an interrupt for one descriptor of a chain that is still running. Software clears the interrupt by writing 1 to a clear bit.

Two small state machines do the work. The request machine has the states `IRQ_IDLE` and `IRQ_PEND`. It takes the transition *raise* (IDLE to PEND) on a qualifying completion. It takes the transition *clear* (PEND to IDLE) on a clear write that does not coincide with a new qualifying completion. It stays in place otherwise. The channel machine has the states `CH_RUN` and `CH_FIN`. It takes *finish* (RUN to FIN, or FIN to FIN) when the whole transfer completes. It takes *restart* (FIN to RUN) when a new transfer starts without a completion in the same cycle. A combinational decoder classifies each completion into "raise" and "finish" before either machine sees it.

Both outputs are registered. A completion, clear write or start seen at a rising edge is reflected in `irq` and `done_sts` right after that same edge.

Top module: `dma_chan_irq`

## Requirements
- R1: After reset, `irq` is 0 and `done_sts` is 0.
- R2: With `chain_mode`=0, a `seg_end` pulse sets `done_sts` to 1. It raises `irq` if and only if `done_irq_en`=1.
- R3: With `chain_mode`=1 and `chain_last`=0, a `seg_end` pulse raises `irq` if and only if `desc_irq_flag`=1, and leaves `done_sts` at 0.
- R4: With `chain_mode`=1 and `chain_last`=1, a `seg_end` pulse sets `done_sts` to 1. It raises `irq` if `done_irq_en`=1 or `desc_irq_flag`=1, and not otherwise.
- R5: When `chain_mode`=0, `desc_irq_flag` has no effect on `irq`. When `chain_mode`=0, `chain_last` has no effect on either output.
- R6: Once raised, `irq` stays 1 on every following cycle until a cycle with `csr_wr`=1 and `csr_clr`=1. After that cycle `irq` is 0. A clear write does not change `done_sts`.
- R7: A write with `csr_wr`=1 and `csr_clr`=0 has no effect on `irq`.
- R8: If a qualifying completion and a clear write (`csr_wr`=1, `csr_clr`=1) occur in the same cycle, `irq` is 1 afterwards.
- R9: A `xfer_start` pulse clears `done_sts` and leaves `irq` unchanged. If a whole-transfer completion occurs in the same cycle as `xfer_start`, `done_sts` is 1 afterwards.
- R10: While `seg_end`=0, the flags `chain_mode`, `desc_irq_flag`, `chain_last` and `done_irq_en` change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Pulse: a new transfer begins |
| seg_end | input | 1 | Pulse: the current descriptor's transfer ended |
| chain_mode | input | 1 | 1 when the channel runs a descriptor chain |
| desc_irq_flag | input | 1 | Interrupt request bit from the current descriptor's pointer word |
| chain_last | input | 1 | 1 when the current descriptor ends the chain |
| done_irq_en | input | 1 | Mode setting: interrupt on completion of the whole transfer |
| csr_wr | input | 1 | Write strobe to the command/status register |
| csr_clr | input | 1 | Value written to the clear-interrupt bit |
| irq | output | 1 | Level interrupt request |
| done_sts | output | 1 | Done status: the whole transfer has completed |

## Verification
Each result is due one clock after its stimulus. A completion, clear write or start is applied at the start of a cycle and is sampled at the rising edge. Both outputs are registered, so the new values appear right after that edge. The bench therefore drives inputs just after a falling edge and reads outputs at the next falling edge. It also reads the outputs one or more idle cycles later, which confirms that nothing changes without a stimulus. The sweep covers all sixteen combinations of the four completion flags. Each run starts from a cleared state. The expected `irq` and `done_sts` values are computed from the requirement formulas.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    typedef enum logic {
        CH_RUN = 1'b0,
        CH_FIN = 1'b1
    } chan_state_e;

    typedef struct packed {
        logic raise;   // completion that requests an interrupt
        logic finish;  // completion that ends the whole transfer
    } cmpl_evt_t;

endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
(
    input  logic      seg_end,
    input  logic      chain_mode,
    input  logic      desc_irq_flag,
    input  logic      chain_last,
    input  logic      done_irq_en,
    output cmpl_evt_t evt
);

    logic whole_done;
    logic want_done_irq;
    logic want_desc_irq;

    always_comb begin
        // outside a chain, every descriptor end is the whole transfer
        whole_done    = seg_end & (~chain_mode | chain_last);
        want_done_irq = whole_done & done_irq_en;
        // the per-descriptor request bit only counts in chaining mode
        want_desc_irq = seg_end & chain_mode & desc_irq_flag;
        evt.finish    = whole_done;
        evt.raise     = want_done_irq | want_desc_irq;
    end

endmodule

// File: rtl/dmairq_req_fsm.sv
module dmairq_req_fsm
    import dmairq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr_hit,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise) state_d = IRQ_PEND;
            // a new event in the clear cycle keeps the request pending
            IRQ_PEND: if (clr_hit && !raise) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PEND);
    end

    // R8
    raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> irq);
    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && clr_hit && !raise) |=> !irq);
    // R6
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_hit) |=> irq);
    // R10
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !raise) |=> !irq);

endmodule

// File: rtl/dmairq_chan_fsm.sv
module dmairq_chan_fsm
    import dmairq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic finish,
    input  logic restart,
    output logic done_sts
);

    chan_state_e state_q;
    chan_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_RUN:  if (finish) state_d = CH_FIN;
            CH_FIN:  if (restart && !finish) state_d = CH_RUN;
            default: state_d = CH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        done_sts = (state_q == CH_FIN);
    end

    // R9
    finish_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_sts);
    // R9
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !finish) |=> !done_sts);
    // R3
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !finish) |=> $stable(done_sts));

endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
    import dmairq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start,
    input  logic seg_end,
    input  logic chain_mode,
    input  logic desc_irq_flag,
    input  logic chain_last,
    input  logic done_irq_en,
    input  logic csr_wr,
    input  logic csr_clr,
    output logic irq,
    output logic done_sts
);

    cmpl_evt_t evt;
    logic      clr_hit;

    always_comb begin
        clr_hit = csr_wr & csr_clr;
    end

    dmairq_decode u_decode (
        .seg_end       (seg_end),
        .chain_mode    (chain_mode),
        .desc_irq_flag (desc_irq_flag),
        .chain_last    (chain_last),
        .done_irq_en   (done_irq_en),
        .evt           (evt)
    );

    dmairq_req_fsm u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (evt.raise),
        .clr_hit (clr_hit),
        .irq     (irq)
    );

    dmairq_chan_fsm u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .finish   (evt.finish),
        .restart  (xfer_start),
        .done_sts (done_sts)
    );

    // R2
    plain_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end && !chain_mode && !done_irq_en && !irq && !csr_wr) |=> !irq);
    // R3
    mid_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end && chain_mode && !chain_last && desc_irq_flag) |=> irq);
    // R4
    last_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end && chain_mode && chain_last) |=> done_sts);
    // R7
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && csr_wr && !csr_clr) |=> irq);

endmodule

// File: tb/tb_dma_chan_irq.sv
module tb_dma_chan_irq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 1'b0;
    logic seg_end = 1'b0;
    logic chain_mode = 1'b0;
    logic desc_irq_flag = 1'b0;
    logic chain_last = 1'b0;
    logic done_irq_en = 1'b0;
    logic csr_wr = 1'b0;
    logic csr_clr = 1'b0;
    logic irq;
    logic done_sts;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_chan_irq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_start    (xfer_start),
        .seg_end       (seg_end),
        .chain_mode    (chain_mode),
        .desc_irq_flag (desc_irq_flag),
        .chain_last    (chain_last),
        .done_irq_en   (done_irq_en),
        .csr_wr        (csr_wr),
        .csr_clr       (csr_clr),
        .irq           (irq),
        .done_sts      (done_sts)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // drive one cycle of stimulus just after a falling edge, return at the next falling edge
    task automatic cycle(input logic st, input logic se, input logic cm, input logic df,
                         input logic cl, input logic de, input logic wr, input logic cv);
        xfer_start = st; seg_end = se; chain_mode = cm; desc_irq_flag = df;
        chain_last = cl; done_irq_en = de; csr_wr = wr; csr_clr = cv;
        @(negedge clk);
        xfer_start = 0; seg_end = 0; chain_mode = 0; desc_irq_flag = 0;
        chain_last = 0; done_irq_en = 0; csr_wr = 0; csr_clr = 0;
    endtask

    task automatic clean();
        cycle(1, 0, 0, 0, 0, 0, 1, 1);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "irq after reset", irq, 1'b0);
        chk("R1", "done after reset", done_sts, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "irq after release", irq, 1'b0);
        chk("R1", "done after release", done_sts, 1'b0);

        // full sweep over the four completion flags
        for (int i = 0; i < 16; i++) begin
            logic cm, df, cl, de, fin, ei;
            string tag;
            cm = i[0]; df = i[1]; cl = i[2]; de = i[3];
            fin = !cm || cl;
            ei  = (fin && de) || (cm && df);
            tag = !cm ? (df ? "R5" : "R2") : (cl ? "R4" : "R3");
            clean();
            chk("R9", "done cleared by start", done_sts, 1'b0);
            chk("R6", "irq cleared", irq, 1'b0);
            // R10: flags without seg_end change nothing
            cycle(0, 0, cm, df, cl, de, 0, 0);
            chk("R10", "irq without seg_end", irq, 1'b0);
            chk("R10", "done without seg_end", done_sts, 1'b0);
            cycle(0, 1, cm, df, cl, de, 0, 0);
            chk(tag, "irq after completion", irq, ei);
            chk(tag, "done after completion", done_sts, fin);
            @(negedge clk);
            chk(tag, "irq holds", irq, ei);
            chk(tag, "done holds", done_sts, fin);
        end

        // R6, R7: pending until a write of 1
        clean();
        cycle(0, 1, 0, 0, 0, 1, 0, 0);
        chk("R2", "irq raised", irq, 1'b1);
        repeat (5) @(negedge clk);
        chk("R6", "irq held over idle", irq, 1'b1);
        cycle(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R7", "write of 0 keeps irq", irq, 1'b1);
        cycle(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R6", "clear value without strobe keeps irq", irq, 1'b1);
        cycle(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R6", "write of 1 clears irq", irq, 1'b0);
        chk("R6", "clear keeps done", done_sts, 1'b1);
        cycle(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R7", "write of 0 keeps irq low", irq, 1'b0);

        // R9: start clears done, leaves irq
        cycle(0, 1, 1, 1, 0, 0, 0, 0);
        chk("R3", "mid-chain irq", irq, 1'b1);
        cycle(0, 1, 1, 0, 1, 1, 0, 0);
        chk("R4", "chain end done", done_sts, 1'b1);
        cycle(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R9", "start clears done", done_sts, 1'b0);
        chk("R9", "start leaves irq", irq, 1'b1);

        // R8: event and clear in the same cycle
        cycle(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R6", "irq cleared before race", irq, 1'b0);
        cycle(0, 1, 1, 1, 0, 0, 1, 1);
        chk("R8", "event beats clear", irq, 1'b1);
        cycle(0, 1, 0, 0, 0, 0, 1, 1);
        chk("R8", "non-qualifying event with clear", irq, 1'b0);
        chk("R2", "done from plain completion", done_sts, 1'b1);

        // R9: start and whole completion together
        cycle(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R9", "done cleared", done_sts, 1'b0);
        cycle(1, 1, 0, 0, 0, 0, 0, 0);
        chk("R9", "completion beats start", done_sts, 1'b1);
        chk("R2", "no irq with enable clear", irq, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule